// File: doc/BRIEF.md
# Speculative Prefetch Staging Buffer

This block keeps track of KV cache blocks that a decode pipeline fetches ahead of demand. While the consumer works on token N, requests for the token N+1 window land in a small staging store. That store is kept apart from the main hot allocation. Each staged entry holds a session index, a block tag and a time-to-live counter. The payload, the DMA engine and the hot region are outside the block; only tags and entry state are kept here.

Three actions remove entries:
- A consume lookup that finds its tag promotes that entry out of staging.
- A mispredict notice for a session drops every entry of that session. The hot region is not touched, so the cost is bounded by draining the stage.
- An entry whose time-to-live runs out is freed automatically.

Hits and misses are tallied per session over fixed windows of events. A session that mispredicts too often is held to a shallow look-ahead depth until it proves accurate again.

Top module: `spec_stage_buf`

## Requirements
- R1: A prefetch (`pfValid`) that is not refused is staged at the next clock edge. `pfBusy` is 0 for it. A later consume with the same session and tag reports a hit.
- R2: A consume whose session and tag match a staged entry raises `cnHit` in the same cycle and frees that entry, so a repeat of the same consume misses.
- R3: A consume that matches no staged entry (wrong session or wrong tag) gives `cnHit`=0 and leaves every staged entry in place.
- R4: An entry is loaded with TTL_INIT (default 20) and loses one unit per `tick`. It can still be consumed after TTL_INIT-1 ticks and is gone after TTL_INIT ticks.
- R5: A mispredict notice (`flValid`, `flSession`) drops all staged entries of that session and no entry of any other session.
- R6: When all 16 entries are occupied, a prefetch is refused (`pfBusy`=1) and not staged.
- R7: A prefetch is refused when its session already has as many staged entries as its current depth limit.
- R8: Each session's depth limit starts at 4. It is re-evaluated when that session's hits plus misses since its last evaluation reach 64. The limit becomes 1 if misses > (hits >> 2), otherwise 4, and both tallies then restart. `qDepth` shows the limit of session `qSession`.
- R9: Every entry freed by a mispredict notice or by TTL expiry counts as one miss of its session. Every consume hit counts as one hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pfValid | input | 1 | Prefetch request strobe |
| pfSession | input | 4 | Session index of the prefetch |
| pfTag | input | 12 | Block tag of the prefetch |
| pfBusy | output | 1 | Prefetch refused this cycle (full or at depth limit) |
| cnValid | input | 1 | Consume lookup strobe |
| cnSession | input | 4 | Session index of the lookup |
| cnTag | input | 12 | Block tag of the lookup |
| cnHit | output | 1 | Lookup found a staged entry, which is promoted |
| flValid | input | 1 | Mispredict notice strobe |
| flSession | input | 4 | Session whose staged entries are dropped |
| tick | input | 1 | Time-to-live aging strobe |
| qSession | input | 4 | Session whose depth limit is shown |
| qDepth | output | 3 | Current look-ahead depth limit of `qSession` |

## Verification
The hardest state to reach from the ports is a depth-limit change. It happens only when one session has gathered exactly 64 counted events, and the ratio at that instant must sit on either side of the misses > hits/4 threshold. The stimulus builds each window deliberately. Misses come in bursts of four from mispredict notices or from group expiry after TTL_INIT ticks. Hits come from single prefetch-consume pairs. Two sessions receive 12 misses + 52 hits and 13 misses + 51 hits, to straddle the threshold. A throttled session is then walked back to full depth, with a probe one event before the window closes.

// File: rtl/pfstage_pkg.sv
`timescale 1ns/100ps
package pfstage_pkg;
  localparam int ENTRIES  = 16;
  localparam int IDX_W    = $clog2(ENTRIES);
  localparam int SESS_W   = 4;
  localparam int SESSIONS = 1 << SESS_W;
  localparam int TTL_W    = 8;

  typedef logic [SESS_W-1:0] sess_t;
  typedef logic [TTL_W-1:0]  ttl_t;

  // strobes from control to the entry store
  typedef struct packed {
    logic               alloc;
    logic [IDX_W-1:0]   allocIdx;
    logic [ENTRIES-1:0] drop;
    logic [ENTRIES-1:0] miss;
    logic               age;
  } stageCtl_t;
endpackage

// File: rtl/pfstage_store.sv
`timescale 1ns/100ps
module pfstage_store
  import pfstage_pkg::*;
#(
  parameter int TAG_W    = 12,
  parameter int TTL_INIT = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  stageCtl_t          ctl,
  input  sess_t              newSess,
  input  logic [TAG_W-1:0]   newTag,
  output logic [ENTRIES-1:0] entValid,
  output sess_t              entSess [ENTRIES],
  output logic [TAG_W-1:0]   entTag  [ENTRIES],
  output ttl_t               entTtl  [ENTRIES]
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        entValid[i] <= 1'b0;
        entSess[i]  <= '0;
        entTag[i]   <= '0;
        entTtl[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ctl.drop[i]) begin
          entValid[i] <= 1'b0;
        end else if (ctl.alloc && ctl.allocIdx == IDX_W'(i)) begin
          entValid[i] <= 1'b1;
          entSess[i]  <= newSess;
          entTag[i]   <= newTag;
          entTtl[i]   <= TTL_W'(TTL_INIT);
        end else if (ctl.age && entValid[i]) begin
          entTtl[i]   <= entTtl[i] - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pfstage_ctrl.sv
`timescale 1ns/100ps
module pfstage_ctrl
  import pfstage_pkg::*;
#(
  parameter int TAG_W   = 12,
  parameter int DEPTH_W = 3
) (
  input  logic [ENTRIES-1:0] entValid,
  input  sess_t              entSess [ENTRIES],
  input  logic [TAG_W-1:0]   entTag  [ENTRIES],
  input  ttl_t               entTtl  [ENTRIES],
  input  logic               pfValid,
  input  sess_t              pfSess,
  input  logic               cnValid,
  input  sess_t              cnSess,
  input  logic [TAG_W-1:0]   cnTag,
  input  logic               flValid,
  input  sess_t              flSess,
  input  logic               tick,
  input  logic [DEPTH_W-1:0] pfLimit,
  output stageCtl_t          ctl,
  output logic               pfBusy,
  output logic               cnHit
);
  logic [ENTRIES-1:0] hitOh, flushMask, expMask;
  logic               hitFound, freeFound;
  logic [IDX_W-1:0]   freeIdx;
  logic [IDX_W:0]     owned;

  always_comb begin
    hitOh     = '0;
    hitFound  = 1'b0;
    freeFound = 1'b0;
    freeIdx   = '0;
    owned     = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!hitFound && cnValid && entValid[i] &&
          entSess[i] == cnSess && entTag[i] == cnTag) begin
        hitOh[i] = 1'b1;
        hitFound = 1'b1;
      end
      if (!freeFound && !entValid[i]) begin
        freeFound = 1'b1;
        freeIdx   = IDX_W'(i);
      end
      if (entValid[i] && entSess[i] == pfSess) owned = owned + 1'b1;
      flushMask[i] = flValid && entValid[i] && entSess[i] == flSess;
      expMask[i]   = tick && entValid[i] && entTtl[i] == TTL_W'(1);
    end
  end

  always_comb begin
    pfBusy       = pfValid && (!freeFound || owned >= (IDX_W+1)'(pfLimit));
    cnHit        = hitFound;
    ctl.alloc    = pfValid && !pfBusy;
    ctl.allocIdx = freeIdx;
    ctl.drop     = hitOh | flushMask | expMask;
    ctl.miss     = (flushMask | expMask) & ~hitOh;
    ctl.age      = tick;
  end
endmodule

// File: rtl/pfstage_acct.sv
`timescale 1ns/100ps
module pfstage_acct
  import pfstage_pkg::*;
#(
  parameter int WINDOW    = 64,
  parameter int DEPTH_MAX = 4,
  parameter int DEPTH_MIN = 1,
  parameter int DEPTH_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hitEn,
  input  sess_t              hitSess,
  input  logic [ENTRIES-1:0] miss,
  input  sess_t              entSess [ENTRIES],
  input  sess_t              qSess,
  input  sess_t              pfSess,
  output logic [DEPTH_W-1:0] qDepth,
  output logic [DEPTH_W-1:0] pfLimit
);
  localparam int CNT_W = $clog2(WINDOW + 2*ENTRIES + 2) + 1;

  logic [SESSIONS-1:0] throttled;

  for (genvar s = 0; s < SESSIONS; s++) begin : g_sess
    logic [CNT_W-1:0] hitCnt, missCnt, missAdd, sumH, sumM;
    logic             thr;

    always_comb begin
      missAdd = '0;
      for (int i = 0; i < ENTRIES; i++)
        if (miss[i] && entSess[i] == sess_t'(s)) missAdd = missAdd + 1'b1;
      sumH = hitCnt + CNT_W'(hitEn && hitSess == sess_t'(s));
      sumM = missCnt + missAdd;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hitCnt  <= '0;
        missCnt <= '0;
        thr     <= 1'b0;
      end else if (sumH + sumM >= CNT_W'(WINDOW)) begin
        thr     <= sumM > (sumH >> 2);
        hitCnt  <= '0;
        missCnt <= '0;
      end else begin
        hitCnt  <= sumH;
        missCnt <= sumM;
      end
    end

    assign throttled[s] = thr;
  end

  assign qDepth  = throttled[qSess]  ? DEPTH_W'(DEPTH_MIN) : DEPTH_W'(DEPTH_MAX);
  assign pfLimit = throttled[pfSess] ? DEPTH_W'(DEPTH_MIN) : DEPTH_W'(DEPTH_MAX);
endmodule

// File: rtl/spec_stage_buf.sv
`timescale 1ns/100ps
module spec_stage_buf
  import pfstage_pkg::*;
#(
  parameter int TAG_W     = 12,
  parameter int TTL_INIT  = 20,
  parameter int WINDOW    = 64,
  parameter int DEPTH_MAX = 4,
  parameter int DEPTH_MIN = 1,
  localparam int DEPTH_W  = $clog2(DEPTH_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pfValid,
  input  logic [SESS_W-1:0]  pfSession,
  input  logic [TAG_W-1:0]   pfTag,
  output logic               pfBusy,
  input  logic               cnValid,
  input  logic [SESS_W-1:0]  cnSession,
  input  logic [TAG_W-1:0]   cnTag,
  output logic               cnHit,
  input  logic               flValid,
  input  logic [SESS_W-1:0]  flSession,
  input  logic               tick,
  input  logic [SESS_W-1:0]  qSession,
  output logic [DEPTH_W-1:0] qDepth
);
  stageCtl_t          ctl;
  logic [ENTRIES-1:0] entValid;
  sess_t              entSess [ENTRIES];
  logic [TAG_W-1:0]   entTag  [ENTRIES];
  ttl_t               entTtl  [ENTRIES];
  logic [DEPTH_W-1:0] pfLimit;

  pfstage_store #(.TAG_W(TAG_W), .TTL_INIT(TTL_INIT)) store (
    .clk(clk), .rstN(rstN), .ctl(ctl), .newSess(pfSession), .newTag(pfTag),
    .entValid(entValid), .entSess(entSess), .entTag(entTag), .entTtl(entTtl)
  );

  pfstage_ctrl #(.TAG_W(TAG_W), .DEPTH_W(DEPTH_W)) ctrl (
    .entValid(entValid), .entSess(entSess), .entTag(entTag), .entTtl(entTtl),
    .pfValid(pfValid), .pfSess(pfSession), .cnValid(cnValid), .cnSess(cnSession),
    .cnTag(cnTag), .flValid(flValid), .flSess(flSession), .tick(tick),
    .pfLimit(pfLimit), .ctl(ctl), .pfBusy(pfBusy), .cnHit(cnHit)
  );

  pfstage_acct #(.WINDOW(WINDOW), .DEPTH_MAX(DEPTH_MAX), .DEPTH_MIN(DEPTH_MIN),
                 .DEPTH_W(DEPTH_W)) acct (
    .clk(clk), .rstN(rstN), .hitEn(cnHit), .hitSess(cnSession), .miss(ctl.miss),
    .entSess(entSess), .qSess(qSession), .pfSess(pfSession),
    .qDepth(qDepth), .pfLimit(pfLimit)
  );
endmodule

// File: rtl/spec_stage_buf_chk.sv
`timescale 1ns/100ps
module spec_stage_buf_chk
  import pfstage_pkg::*;
#(
  parameter int DEPTH_MAX = 4,
  parameter int DEPTH_MIN = 1,
  parameter int DEPTH_W   = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               pfValid,
  input logic               pfBusy,
  input logic               cnValid,
  input logic               cnHit,
  input logic               flValid,
  input logic [SESS_W-1:0]  flSession,
  input logic               tick,
  input logic [DEPTH_W-1:0] qDepth,
  input logic [ENTRIES-1:0] entValid,
  input sess_t              entSess [ENTRIES]
);
  sess_t lastFl;
  logic  flLeft;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) lastFl <= '0;
    else       lastFl <= flSession;

  always_comb begin
    flLeft = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (entValid[i] && entSess[i] == lastFl) flLeft = 1'b1;
  end

  // R6
  full_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && &entValid) |-> pfBusy);

  // R1
  alloc_grow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !pfBusy && !cnValid && !flValid && !tick)
      |=> $countones(entValid) == $past($countones(entValid)) + 1);

  // R2
  hit_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnValid && cnHit && !pfValid)
      |=> $countones(entValid) < $past($countones(entValid)));

  // R5
  flush_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flValid && !pfValid) |=> !flLeft);

  // R3
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cnValid && !flValid && !tick) |=> ($past(entValid) & ~entValid) == '0);

  // R8
  depth_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    qDepth == DEPTH_W'(DEPTH_MAX) || qDepth == DEPTH_W'(DEPTH_MIN));
endmodule

bind spec_stage_buf spec_stage_buf_chk #(
  .DEPTH_MAX(DEPTH_MAX), .DEPTH_MIN(DEPTH_MIN), .DEPTH_W(DEPTH_W)
) chk (
  .clk(clk), .rstN(rstN), .pfValid(pfValid), .pfBusy(pfBusy),
  .cnValid(cnValid), .cnHit(cnHit), .flValid(flValid), .flSession(flSession),
  .tick(tick), .qDepth(qDepth), .entValid(entValid), .entSess(entSess)
);

// File: tb/spec_stage_buf_test.sv
`timescale 1ns/100ps
module spec_stage_buf_test;
  localparam int TTL = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pfValid = 0, cnValid = 0, flValid = 0, tick = 0;
  logic [3:0] pfSession = 0, cnSession = 0, flSession = 0, qSession = 0;
  logic [11:0] pfTag = 0, cnTag = 0;
  logic pfBusy, cnHit;
  logic [2:0] qDepth;

  always #2 clk = ~clk;

  spec_stage_buf #(.TTL_INIT(TTL)) uut (
    .clk(clk), .rstN(rstN), .pfValid(pfValid), .pfSession(pfSession), .pfTag(pfTag),
    .pfBusy(pfBusy), .cnValid(cnValid), .cnSession(cnSession), .cnTag(cnTag),
    .cnHit(cnHit), .flValid(flValid), .flSession(flSession), .tick(tick),
    .qSession(qSession), .qDepth(qDepth)
  );

  typedef struct { int kind; int exp; string req; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // monitor: compares queued expectations against the outputs of this cycle
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      while (q.size() > 0) begin
        item_t it;
        int act;
        it = q.pop_front();
        act = (it.kind == 0) ? int'(pfBusy) : (it.kind == 1) ? int'(cnHit) : int'(qDepth);
        checks++;
        if (act != it.exp) begin
          fails++;
          $display("FAIL %s kind=%0d actual=%0d expected=%0d", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic step(input bit p, input int ps, input int pt, input bit c, input int cs,
                      input int ct, input bit f, input int fs, input bit t);
    @(negedge clk);
    #0.5;
    pfValid = p; pfSession = 4'(ps); pfTag = 12'(pt);
    cnValid = c; cnSession = 4'(cs); cnTag = 12'(ct);
    flValid = f; flSession = 4'(fs); tick = t;
  endtask

  task automatic push(input int kind, input int exp, input string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic idle();                                     step(0,0,0,0,0,0,0,0,0); endtask
  task automatic doTick();                                   step(0,0,0,0,0,0,0,0,1); endtask
  task automatic doFl(input int s);                          step(0,0,0,0,0,0,1,s,0); endtask
  task automatic doPf(input int s, input int t, input int b, input string r);
    step(1,s,t,0,0,0,0,0,0); push(0, b, r);
  endtask
  task automatic doCn(input int s, input int t, input int h, input string r);
    step(0,0,0,1,s,t,0,0,0); push(1, h, r);
  endtask
  task automatic chkDepth(input int s, input int d, input string r);
    idle(); qSession = 4'(s); push(2, d, r);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state
    chkDepth(0, 4, "R8 reset depth");
    doCn(0, 0, 0, "R3 reset empty");

    // R1 / R2 basic staging and promotion
    doPf(1, 'h11, 0, "R1 accept");
    doCn(1, 'h11, 1, "R2 hit");
    doCn(1, 'h11, 0, "R2 freed");

    // R3 mismatches leave the entry
    doPf(1, 'h22, 0, "R1 accept");
    doCn(2, 'h22, 0, "R3 wrong session");
    doCn(1, 'h23, 0, "R3 wrong tag");
    doCn(1, 'h22, 1, "R3 entry kept");

    // R7 depth limit for an unthrottled session
    for (int k = 0; k < 4; k++) doPf(1, 'h30 + k, 0, "R7 within depth");
    doPf(1, 'h3f, 1, "R7 at depth busy");
    doCn(1, 'h3f, 0, "R7 refused not staged");
    for (int k = 0; k < 4; k++) doCn(1, 'h30 + k, 1, "R7 drain");

    // R6 full buffer
    for (int s = 8; s < 12; s++)
      for (int k = 0; k < 4; k++) doPf(s, 'h80 + k, 0, "R6 fill");
    doPf(12, 'h99, 1, "R6 full busy");
    doCn(12, 'h99, 0, "R6 refused not staged");
    for (int s = 8; s < 12; s++) doFl(s);

    // R5 flush one session only
    doPf(6, 'h60, 0, "R5 stage");
    doPf(7, 'h70, 0, "R5 stage");
    doPf(7, 'h71, 0, "R5 stage");
    doFl(7);
    doCn(7, 'h70, 0, "R5 flushed");
    doCn(7, 'h71, 0, "R5 flushed");
    doCn(6, 'h60, 1, "R5 other session kept");

    // R4 time-to-live
    doPf(5, 'h50, 0, "R4 stage");
    repeat (TTL - 1) doTick();
    doCn(5, 'h50, 1, "R4 alive before expiry");
    doPf(5, 'h51, 0, "R4 stage");
    repeat (TTL) doTick();
    doCn(5, 'h51, 0, "R4 expired");

    // R9 / R8 flush misses throttle session 2
    for (int r = 0; r < 16; r++) begin
      for (int k = 0; k < 4; k++) doPf(2, 'h200 + k, 0, "R9 stage");
      doFl(2);
    end
    chkDepth(2, 1, "R8 R9 throttled by flush misses");
    doPf(2, 'h2a0, 0, "R7 throttled one allowed");
    doPf(2, 'h2a1, 1, "R7 throttled second busy");
    doCn(2, 'h2a0, 1, "R9 hit");
    for (int k = 1; k < 63; k++) begin
      doPf(2, 'h300 + k, 0, "R9 stage");
      doCn(2, 'h300 + k, 1, "R9 hit");
    end
    chkDepth(2, 1, "R8 window not closed at 63");
    doPf(2, 'h3ff, 0, "R9 stage");
    doCn(2, 'h3ff, 1, "R9 hit");
    chkDepth(2, 4, "R8 recovered after 64 hits");

    // R8 threshold: 12 misses + 52 hits keeps depth
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 4; k++) doPf(3, 'h400 + k, 0, "R9 stage");
      doFl(3);
    end
    for (int k = 0; k < 52; k++) begin
      doPf(3, 'h500 + k, 0, "R9 stage");
      doCn(3, 'h500 + k, 1, "R9 hit");
    end
    chkDepth(3, 4, "R8 12 misses vs 52 hits");

    // R8 threshold: 13 misses + 51 hits throttles
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 4; k++) doPf(13, 'h600 + k, 0, "R9 stage");
      doFl(13);
    end
    doPf(13, 'h6f0, 0, "R9 stage");
    doFl(13);
    for (int k = 0; k < 51; k++) begin
      doPf(13, 'h700 + k, 0, "R9 stage");
      doCn(13, 'h700 + k, 1, "R9 hit");
    end
    chkDepth(13, 1, "R8 13 misses vs 51 hits");

    // R9 expiry counts as misses
    for (int r = 0; r < 16; r++) begin
      for (int k = 0; k < 4; k++) doPf(4, 'h800 + k, 0, "R9 expiry stage");
      repeat (TTL) doTick();
    end
    chkDepth(4, 1, "R9 throttled by expiry misses");
    chkDepth(5, 4, "R8 unrelated session full depth");

    idle();
    idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule